// File: doc/BRIEF.md
# Instruction Prefix Immediate Unit

This unit holds an 11-bit prefix value that a dedicated prefix instruction writes and that lives for exactly one following instruction. While that following instruction is current, the unit joins the held value with the instruction's own 5-bit short immediate to form a wide immediate. Every other accepted instruction clears the held value, so it is non-zero only directly after a prefix.

The unit also keeps the prefix and the instruction that consumes it together. It holds off interrupt acceptance between the two, and it passes a skip on to the consumer when a conditional skip annuls the prefix. The decoder drives one strobe per accepted instruction along with the prefix flag, the prefix field, the short immediate and an annul input from the skip logic. State moves only on strobed cycles.

Top module: `prefix_imm_unit`

## Requirements
- R1: On a strobed, non-annulled prefix instruction (`is_prefix`=1), the held value takes `prefix_field` at that clock edge.
- R2: Any other strobed instruction clears the held value to zero at that clock edge. This covers non-prefix instructions and annulled instructions of any kind.
- R3: `imm_out` is combinational. Bits 4..0 equal `short_imm`, bits 15..5 equal the held value, and bits 31..16 are zero.
- R4: `irq_inhibit` is 1 for the instruction slot that follows any strobed prefix instruction, and is 0 after any other strobed instruction.
- R5: If a strobed prefix instruction is annulled by `skip_in` while `pair_skip` is 0, then `pair_skip` is 1 for the next instruction slot. After any other strobed instruction it is 0.
- R6: An instruction is annulled when `skip_in` or `pair_skip` is 1. An annulled prefix leaves the held value at zero, and it does not start a second chained pair skip.
- R7: Cycles with `insn_valid`=0 leave the held value, `irq_inhibit` and `pair_skip` unchanged.
- R8: Reset (`rst_n`=0, synchronous) sets the held value, `irq_inhibit` and `pair_skip` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | One pulse per accepted instruction |
| is_prefix | input | 1 | Current instruction is a prefix |
| prefix_field | input | 11 | Prefix value carried by a prefix instruction |
| short_imm | input | 5 | Short immediate of the current instruction |
| skip_in | input | 1 | Conditional skip annuls the current instruction |
| imm_out | output | 32 | Assembled wide immediate |
| irq_inhibit | output | 1 | Interrupt acceptance blocked for this slot |
| pair_skip | output | 1 | Current slot must be annulled as the second half of a pair |

## Verification
A wrong held value appears in bits 15..5 of `imm_out` in the very next instruction slot, because the immediate is combinational from the register. A held value that is not cleared shows up as non-zero upper bits on the instruction two slots after a prefix. Errors in the inhibit flag or the pair-skip flag appear on their own outputs one strobe after the cause. Idle cycles between strobes reveal any state that drifts when no instruction is accepted.

// File: rtl/prefix_imm_unit.sv
module prefix_imm_unit #(
  parameter int DATA_W = 32,
  parameter int PFX_W  = 11,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic              is_prefix,
  input  logic [PFX_W-1:0]  prefix_field,
  input  logic [IMM_W-1:0]  short_imm,
  input  logic              skip_in,
  output logic [DATA_W-1:0] imm_out,
  output logic              irq_inhibit,
  output logic              pair_skip
);
  localparam int HI_W = DATA_W - PFX_W - IMM_W;

  logic [PFX_W-1:0] k_q;
  logic             annul;
  logic             pfx_exec;

  assign annul    = skip_in | pair_skip;
  assign pfx_exec = is_prefix & ~annul;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q         <= '0;
      irq_inhibit <= 1'b0;
      pair_skip   <= 1'b0;
    end else if (insn_valid) begin
      k_q         <= pfx_exec ? prefix_field : '0;
      irq_inhibit <= is_prefix;
      pair_skip   <= is_prefix & skip_in & ~pair_skip;
    end
  end

  assign imm_out = {{HI_W{1'b0}}, k_q, short_imm};

  // R1
  prefix_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && is_prefix && !skip_in && !pair_skip |=> imm_out[IMM_W +: PFX_W] == $past(prefix_field));
  // R2
  prefix_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !(is_prefix && !skip_in && !pair_skip) |=> imm_out[IMM_W +: PFX_W] == '0);
  // R4
  inhibit_after_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> irq_inhibit == $past(is_prefix));
  // R5
  pair_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> pair_skip == $past(is_prefix && skip_in && !pair_skip));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> $stable(imm_out[IMM_W +: PFX_W]) && $stable(irq_inhibit) && $stable(pair_skip));
endmodule

// File: tb/prefix_imm_unit_bench.sv
module prefix_imm_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        is_prefix = 1'b0;
  logic [10:0] prefix_field = '0;
  logic [4:0]  short_imm = '0;
  logic        skip_in = 1'b0;
  logic [31:0] imm_out;
  logic        irq_inhibit;
  logic        pair_skip;

  int n_tests = 0;
  int n_fail  = 0;
  logic [10:0] exp_k = '0;
  logic        exp_inh = 1'b0;
  logic        exp_ps = 1'b0;
  string       last_req = "R8";
  bit          done = 0;

  always #10 clk = ~clk;

  prefix_imm_unit u_prefix_imm_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .is_prefix(is_prefix),
    .prefix_field(prefix_field), .short_imm(short_imm), .skip_in(skip_in),
    .imm_out(imm_out), .irq_inhibit(irq_inhibit), .pair_skip(pair_skip));

  function automatic logic [31:0] exp_imm(logic [10:0] k, logic [4:0] s);
    return {16'h0000, k, s};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic p, logic [10:0] f, logic [4:0] s, logic sk);
    logic an;
    @(negedge clk);
    insn_valid = v; is_prefix = p; prefix_field = f; short_imm = s; skip_in = sk;
    #1;
    check({last_req, " R3"}, "imm_out", imm_out, exp_imm(exp_k, s));
    check(exp_inh ? "R4" : "R4/clear", "irq_inhibit", {31'd0, irq_inhibit}, {31'd0, exp_inh});
    check(exp_ps ? "R5" : "R5/clear", "pair_skip", {31'd0, pair_skip}, {31'd0, exp_ps});
    @(posedge clk);
    if (v) begin
      an = sk | exp_ps;
      if (p && !an) last_req = "R1";
      else if (p) last_req = "R6";
      else last_req = "R2";
      exp_k   = (p && !an) ? f : 11'd0;
      exp_ps  = p && sk && !exp_ps;
      exp_inh = p;
    end else begin
      last_req = "R7";
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "imm_out reset", imm_out, 32'd0);
    check("R8", "irq_inhibit reset", {31'd0, irq_inhibit}, 32'd0);
    check("R8", "pair_skip reset", {31'd0, pair_skip}, 32'd0);
    rst_n = 1'b1;
    // R1 R3 all-ones prefix, R2 clears on consumer
    step(1, 1, 11'h7FF, 5'h00, 0);
    step(1, 0, 11'h000, 5'h1F, 0);
    step(1, 0, 11'h000, 5'h1F, 0);
    // R7 idle gaps hold prefix and inhibit
    step(1, 1, 11'h2A5, 5'h03, 0);
    step(0, 1, 11'h111, 5'h04, 1);
    step(0, 0, 11'h000, 5'h05, 0);
    step(1, 0, 11'h000, 5'h06, 0);
    // R5 R6 annulled prefix then annulled consumer that is itself a prefix
    step(1, 1, 11'h155, 5'h00, 1);
    step(1, 1, 11'h0AA, 5'h01, 0);
    step(1, 0, 11'h000, 5'h02, 0);
    // back-to-back executed prefixes
    step(1, 1, 11'h001, 5'h00, 0);
    step(1, 1, 11'h400, 5'h00, 0);
    step(1, 0, 11'h000, 5'h10, 0);
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 5) != 0, ($urandom % 5) < 2, 11'($urandom), 5'($urandom),
           ($urandom % 5) == 0);
    end
    step(1, 0, 11'h000, 5'h00, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule